// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Flag Register

This block is the add/subtract slice of a 32-bit datapath. It takes two operands, picks one of six arithmetic operations and returns a 32-bit result in the same cycle. One carry-propagate adder serves every operation. The subtract forms feed the adder with an inverted second input. The reversed forms swap the operands in front of that inversion. The carry-chained forms use the stored carry flag as carry-in, and on subtraction that carry acts as an inverted borrow.

A small register holds the four condition flags: negative, zero, carry and overflow. When flag update is requested in register mode, the flags take the values of the current operation at the next rising clock edge. Otherwise they keep their value. Because the chained forms read the registered carry, software can build 64-bit, 96-bit or wider sums and differences one word per cycle. Two program-counter-relative source modes form addresses. In both, the first operand is the instruction address plus 8, with its low bits masked. The wide form adds or subtracts a 12-bit unsigned immediate. The compact form adds a word-scaled 8-bit immediate. Neither program-counter mode ever writes the flags.

There is no state machine. The block's only state is the flag register. It has two conditions, hold and load, and loads only when flag update is requested and the mode is register mode.

Top module: `addsub_unit`

## Requirements
- R1: In register mode (mode_i = 0), op_i = 0 gives opa_i + opb_i and op_i = 1 gives opa_i + opb_i + C, where C is flags_o[1]. All results are modulo 2^32.
- R2: In register mode, op_i = 2 gives opa_i - opb_i. op_i = 3 gives opa_i - opb_i, minus one more when C is 0.
- R3: In register mode, op_i = 4 gives opb_i - opa_i. op_i = 5 gives opb_i - opa_i, minus one more when C is 0.
- R4: When set_flags_i is 1 in register mode, at the next rising edge flags_o[3] (N) becomes result bit 31 and flags_o[2] (Z) becomes 1 exactly when the result is zero.
- R5: On the same update, flags_o[1] (C) becomes the unsigned carry-out for the add forms. For the subtract forms it becomes 1 when no borrow occurred (minuend >= subtrahend plus the borrow-in).
- R6: On the same update, flags_o[0] (V) becomes 1 exactly when the signed two's-complement result overflows.
- R7: When set_flags_i is 0, flags_o keeps its value across the clock edge.
- R8: With mode_i = 1, the result is ((opa_i + 8) with bit 1 cleared) minus imm_i[11:0] when op_i = 2, and plus imm_i[11:0] for any other op_i.
- R9: With mode_i = 2, the result is ((opa_i + 8) with bits 1:0 cleared) + 4*imm_i[7:0], so its low two bits are always zero.
- R10: When mode_i is not 0, flags_o does not change, whatever set_flags_i is.
- R11: While rst_n is low, flags_o is held at 0.
- R12: An add (op 0) or subtract (op 2) with flag update on the low word, followed one cycle per word by op 1 or op 3 with flag update on the higher words, yields the exact 64-bit or 96-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_i | input | 3 | Operation: 0 add, 1 add with carry, 2 sub, 3 sub with carry, 4 reverse sub, 5 reverse sub with carry |
| mode_i | input | 2 | Source mode: 0 register, 1 wide PC-relative, 2 compact PC-relative |
| opa_i | input | 32 | First operand, or instruction address in the PC-relative modes |
| opb_i | input | 32 | Second operand in register mode |
| imm_i | input | 12 | Immediate for the PC-relative modes |
| set_flags_i | input | 1 | Request a flag update at the next edge |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
The hardest cases to reach are the carry-chained operations, because their behaviour depends on a carry that only an earlier flag-setting operation can leave behind. To get there, the stimulus first runs a preload operation (0xFFFFFFFF + 1 for carry set, 0 + 0 for carry clear) and then applies each tabled vector under both carry values. The multiword sequences reach the same state in a natural way: the low-word operation leaves the carry and the next word consumes it.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_RSB = 3'd4,
        OP_RSC = 3'd5
    } arith_op_e;

    typedef enum logic [1:0] {
        SRC_REG     = 2'd0,
        SRC_PC_WIDE = 2'd1,
        SRC_PC_WORD = 2'd2
    } src_mode_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int FLAG_W = 4;

endpackage

// File: rtl/addsub_opsel.sv
module addsub_opsel
    import addsub_pkg::*;
#(
    parameter int DW     = 32,
    parameter int IMMW   = 12,
    parameter int PC_OFS = 8
) (
    input  logic [2:0]      op_i,
    input  logic [1:0]      mode_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opb_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            carry_i,
    output logic [DW-1:0]   x_o,
    output logic [DW-1:0]   y_o,
    output logic            cin_o
);

    localparam int CIMMW = IMMW - 4;

    logic [DW-1:0] pc_base;
    logic [DW-1:0] wide_imm;
    logic [DW-1:0] word_imm;
    logic [DW-1:0] first, second;
    logic          swap, invert, use_carry;

    assign pc_base  = opa_i + DW'(PC_OFS);
    assign wide_imm = {{(DW-IMMW){1'b0}}, imm_i};
    assign word_imm = {{(DW-CIMMW-2){1'b0}}, imm_i[CIMMW-1:0], 2'b00};

    always_comb begin
        swap      = 1'b0;
        invert    = 1'b0;
        use_carry = 1'b0;
        unique case (op_i)
            OP_ADC:  use_carry = 1'b1;
            OP_SUB:  invert    = 1'b1;
            OP_SBC:  begin invert = 1'b1; use_carry = 1'b1; end
            OP_RSB:  begin invert = 1'b1; swap = 1'b1; end
            OP_RSC:  begin invert = 1'b1; swap = 1'b1; use_carry = 1'b1; end
            default: ;
        endcase
    end

    assign first  = swap ? opb_i : opa_i;
    assign second = swap ? opa_i : opb_i;

    always_comb begin
        unique case (mode_i)
            SRC_PC_WIDE: begin
                x_o = pc_base & ~DW'(2);
                if (op_i == OP_SUB) begin
                    y_o   = ~wide_imm;
                    cin_o = 1'b1;
                end else begin
                    y_o   = wide_imm;
                    cin_o = 1'b0;
                end
            end
            SRC_PC_WORD: begin
                x_o   = pc_base & ~DW'(3);
                y_o   = word_imm;
                cin_o = 1'b0;
            end
            default: begin
                x_o   = first;
                y_o   = invert ? ~second : second;
                cin_o = use_carry ? carry_i : invert;
            end
        endcase
    end

endmodule

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]     x_i,
    input  logic [DW-1:0]     y_i,
    input  logic              cin_i,
    output logic [DW-1:0]     sum_o,
    output logic [FLAG_W-1:0] flags_o
);

    logic [DW:0] wide_sum;

    assign wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cin_i};
    assign sum_o    = wide_sum[DW-1:0];

    always_comb begin
        flags_o         = '0;
        flags_o[FLAG_N] = wide_sum[DW-1];
        flags_o[FLAG_Z] = (wide_sum[DW-1:0] == '0);
        flags_o[FLAG_C] = wide_sum[DW];
        flags_o[FLAG_V] = (x_i[DW-1] == y_i[DW-1]) && (wide_sum[DW-1] != x_i[DW-1]);
    end

endmodule

// File: rtl/addsub_flagreg.sv
module addsub_flagreg
    import addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLAG_W-1:0] next_i,
    output logic [FLAG_W-1:0] flags_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else if (load_i) begin
            flags_o <= next_i;
        end
    end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int DW     = 32,
    parameter int IMMW   = 12,
    parameter int PC_OFS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic [1:0]      mode_i,
    input  logic [DW-1:0]   opa_i,
    input  logic [DW-1:0]   opb_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic            set_flags_i,
    output logic [DW-1:0]   result_o,
    output logic [3:0]      flags_o
);

    logic [DW-1:0]     x, y;
    logic              cin;
    logic [FLAG_W-1:0] new_flags;
    logic              flag_load;

    addsub_opsel #(.DW(DW), .IMMW(IMMW), .PC_OFS(PC_OFS)) u_opsel (
        .op_i    (op_i),
        .mode_i  (mode_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .imm_i   (imm_i),
        .carry_i (flags_o[FLAG_C]),
        .x_o     (x),
        .y_o     (y),
        .cin_o   (cin)
    );

    addsub_core #(.DW(DW)) u_core (
        .x_i     (x),
        .y_i     (y),
        .cin_i   (cin),
        .sum_o   (result_o),
        .flags_o (new_flags)
    );

    assign flag_load = set_flags_i && (mode_i == SRC_REG);

    addsub_flagreg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (flag_load),
        .next_i  (new_flags),
        .flags_o (flags_o)
    );

endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic [1:0]  mode_i,
    input logic [31:0] opa_i,
    input logic [31:0] opb_i,
    input logic        set_flags_i,
    input logic [31:0] result_o,
    input logic [3:0]  flags_o
);

    assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && op_i == 3'd0) |-> result_o == opa_i + opb_i);

    assert_rsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && op_i == 3'd4) |-> result_o == opb_i - opa_i);

    assert_nz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && mode_i == 2'd0) |=>
            (flags_o[3] == $past(result_o[31])) && (flags_o[2] == ($past(result_o) == 32'd0)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o));

    assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2) |-> result_o[1:0] == 2'b00);

    assert_pc_noflags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd0) |=> $stable(flags_o));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> flags_o == 4'd0);

endmodule

bind addsub_unit addsub_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .mode_i      (mode_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .flags_o     (flags_o)
);

// File: tb/sim_addsub_unit.sv
`timescale 1ns/1ps
module sim_addsub_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [1:0]  mode;
    logic [31:0] opa, opb;
    logic [11:0] imm;
    logic        setf;
    logic [31:0] result;
    logic [3:0]  flags;

    int errors = 0;
    int checks = 0;
    logic [3:0]  mflags = 4'd0;
    logic [31:0] last_res;

    always #4 clk = ~clk;

    addsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .mode_i(mode), .opa_i(opa),
        .opb_i(opb), .imm_i(imm), .set_flags_i(setf), .result_o(result), .flags_o(flags)
    );

    // {op, a, b}
    localparam logic [66:0] VEC [12] = '{
        {3'd0, 32'hFFFF_FFFF, 32'h0000_0001},
        {3'd0, 32'h7FFF_FFFF, 32'h0000_0001},
        {3'd2, 32'h8000_0000, 32'h0000_0001},
        {3'd2, 32'h0000_0000, 32'h0000_0000},
        {3'd1, 32'hFFFF_FFFF, 32'h0000_0000},
        {3'd1, 32'h7FFF_FFFF, 32'h0000_0000},
        {3'd3, 32'h0000_0000, 32'h0000_0000},
        {3'd3, 32'h8000_0000, 32'h0000_0000},
        {3'd4, 32'h0000_0001, 32'h0000_0000},
        {3'd4, 32'h0000_0005, 32'h0000_0003},
        {3'd5, 32'h0000_0000, 32'h0000_0000},
        {3'd5, 32'h0000_0001, 32'h8000_0000}
    };

    // returns {N, Z, C, V, result}
    function automatic logic [35:0] model(input logic [2:0] o, input logic [1:0] m,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [11:0] im, input logic cf);
        logic [31:0] p, q, r, base;
        logic [32:0] w;
        logic        c, v, borrow;
        p = a; q = b; c = 1'b0; v = 1'b0;
        if (m == 2'd1) begin
            base = (a + 32'd8) & ~32'h2;
            r = (o == 3'd2) ? base - {20'd0, im} : base + {20'd0, im};
        end else if (m == 2'd2) begin
            base = (a + 32'd8) & ~32'h3;
            r = base + {22'd0, im[7:0], 2'b00};
        end else if (o == 3'd0 || o == 3'd1) begin
            w = {1'b0, p} + {1'b0, q} + {32'd0, (o == 3'd1) ? cf : 1'b0};
            r = w[31:0]; c = w[32];
            v = (p[31] == q[31]) && (r[31] != p[31]);
        end else begin
            if (o == 3'd4 || o == 3'd5) begin p = b; q = a; end
            borrow = (o == 3'd3 || o == 3'd5) ? ~cf : 1'b0;
            r = p - q - {31'd0, borrow};
            c = ({1'b0, p} >= ({1'b0, q} + {32'd0, borrow}));
            v = (p[31] != q[31]) && (r[31] != p[31]);
        end
        return {r[31], (r == 32'd0), c, v, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic run(input logic [2:0] o, input logic [1:0] m, input logic [31:0] a,
                       input logic [31:0] b, input logic [11:0] im, input logic s, input string tag);
        logic [35:0] e;
        op = o; mode = m; opa = a; opb = b; imm = im; setf = s;
        #1;
        e = model(o, m, a, b, im, mflags[1]);
        check(result === e[31:0], tag, result, e[31:0]);
        last_res = result;
        @(posedge clk); #1;
        if (s && m == 2'd0) mflags = e[35:32];
        check(flags === mflags, {tag, " R4 R5 R6 R7 R10 flags"}, {28'd0, flags}, {28'd0, mflags});
        @(negedge clk);
    endtask

    task automatic set_carry(input logic cv);
        if (cv) run(3'd0, 2'd0, 32'hFFFF_FFFF, 32'd1, 12'd0, 1'b1, "R5 preload C=1");
        else    run(3'd0, 2'd0, 32'd0, 32'd0, 12'd0, 1'b1, "R5 preload C=0");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] s64;
        logic [95:0] d96, x96, y96;
        logic [31:0] lo, mid;
        rst_n = 1'b0; op = 3'd0; mode = 2'd0; opa = 32'hFFFF_FFFF; opb = 32'd1;
        imm = 12'd0; setf = 1'b1;
        repeat (3) @(negedge clk);
        check(flags === 4'd0, "R11 flags under reset", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;

        // tabled vectors under both carry values
        for (int i = 0; i < 12; i++) begin
            for (int cv = 0; cv < 2; cv++) begin
                logic [2:0] vo;
                vo = VEC[i][66:64];
                set_carry(cv[0]);
                run(vo, 2'd0, VEC[i][63:32], VEC[i][31:0], 12'd0, 1'b1,
                    (vo < 3'd2) ? "R1 add" : (vo < 3'd4) ? "R2 sub" : "R3 rsb");
            end
        end

        // R7: no update without request
        set_carry(1'b1);
        run(3'd2, 2'd0, 32'd0, 32'd5, 12'd0, 1'b0, "R7 hold");
        run(3'd1, 2'd0, 32'd10, 32'd20, 12'd0, 1'b0, "R7 adc uses held C");

        // R8 / R10: wide PC-relative
        run(3'd0, 2'd1, 32'h0000_1006, 32'd0, 12'd4095, 1'b1, "R8 R10 pc add");
        check(last_res === 32'h0000_200B, "R8 pc add value", last_res, 32'h0000_200B);
        run(3'd2, 2'd1, 32'h0000_1006, 32'd0, 12'h010, 1'b1, "R8 R10 pc sub");
        check(last_res === 32'h0000_0FFC, "R8 pc sub value", last_res, 32'h0000_0FFC);

        // R9: compact PC-relative
        set_carry(1'b0);
        run(3'd0, 2'd2, 32'h0000_1003, 32'd0, 12'h0FF, 1'b1, "R9 R10 pc word");
        check(last_res === 32'h0000_1404, "R9 pc word value", last_res, 32'h0000_1404);

        // R12: 64-bit add chain
        run(3'd0, 2'd0, 32'hFFFF_FFF0, 32'h0000_0020, 12'd0, 1'b1, "R12 add lo");
        lo = last_res;
        run(3'd1, 2'd0, 32'h1234_5678, 32'h0FFF_FFFF, 12'd0, 1'b1, "R12 adc hi");
        s64 = 64'h1234_5678_FFFF_FFF0 + 64'h0FFF_FFFF_0000_0020;
        check({last_res, lo} === s64, "R12 64-bit sum hi", last_res, s64[63:32]);

        // R12: 96-bit subtract chain
        x96 = 96'h0000_0001_0000_0000_0000_0005;
        y96 = 96'h0000_0000_0000_0001_0000_0009;
        run(3'd2, 2'd0, x96[31:0],  y96[31:0],  12'd0, 1'b1, "R12 sub lo");
        lo = last_res;
        run(3'd3, 2'd0, x96[63:32], y96[63:32], 12'd0, 1'b1, "R12 sbc mid");
        mid = last_res;
        run(3'd3, 2'd0, x96[95:64], y96[95:64], 12'd0, 1'b1, "R12 sbc hi");
        d96 = x96 - y96;
        check({last_res, mid, lo} === d96, "R12 96-bit difference mid", mid, d96[63:32]);

        // R11: reset again clears loaded flags
        set_carry(1'b1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(flags === 4'd0, "R11 reset clears", {28'd0, flags}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule